// File: doc/BRIEF.md
# Dithered PWM Compare Channel

This block is one compare/capture channel of a timer, together with the counter it watches. Software writes a shadow buffer and raises an update strobe. The new value moves into the active 32-bit register only at the next counter wrap, so a PWM frame never mixes an old setting with a new one. In the PWM modes the channel compares the counter with the active register and drives a registered waveform. A 2-bit resolution select divides that register into an integer compare field in the upper bits and a dither count in the low bits.

The dither count sets how many frames, out of each group of 2^n, get one extra cycle of pulse width. An accumulator spreads those wider frames evenly across the group, so the average duty cycle gains n bits of resolution. In match-frequency mode the compare field sets the counter period instead, and the output toggles once per period. In capture mode, an input event copies the counter into the register for software to read. A flag marks an unread capture, and a second flag records a capture that arrived while an earlier one was still unread.

Top module: `dpwm_channel`

## Requirements
- R1: After reset the active register, the counter, the waveform output and both capture flags are all zero.
- R2: A write to the shadow buffer never changes the active register by itself. An update strobe loads the buffer into the active register on the first counter wrap at or after the strobe, and not earlier.
- R3: The resolution select res_i gives the dither width n: 0 gives n=0, 1 gives n=4, 2 gives n=5, 3 gives n=6. The compare field is register bits [31:n] and the dither count D is bits [n-1:0].
- R4: In PWM mode (mode_i 0, or its alias 3), pwm_o is the registered result of counter < effective compare, one cycle behind the counter. The effective compare is the compare field plus one in an extended frame, so a frame of P cycles is high for min(effective compare, P) cycles.
- R5: With the register held constant, exactly D of every 2^n consecutive frames are extended. The high-cycle total over any window of P*2^n cycles is D*min(C+1,P) + (2^n-D)*min(C,P).
- R6: The counter counts up from 0. In modes 0, 2 and 3 it wraps to 0 on the cycle after it reaches or exceeds period_i, which gives P = period_i+1.
- R7: In match-frequency mode (mode_i 1), the counter wraps at the compare field, and pwm_o toggles exactly once per wrap.
- R8: In capture mode (mode_i 2), a capture_i pulse copies the current counter value into the active register and sets cap_flag_o. pwm_o stays low, and update strobes have no effect on the active register.
- R9: read_i clears cap_flag_o and cap_ovf_o. A capture while cap_flag_o is set and without read_i sets cap_ovf_o. A capture in the same cycle as read_i leaves cap_flag_o set and cap_ovf_o clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 PWM, 1 match-frequency, 2 capture, 3 PWM |
| res_i | input | 2 | Dither resolution select |
| period_i | input | 32 | Counter top value outside match-frequency mode |
| buf_wr_i | input | 1 | Shadow buffer write enable |
| buf_data_i | input | 32 | Shadow buffer write data |
| update_i | input | 1 | Update strobe, applied at the next wrap |
| capture_i | input | 1 | Capture event |
| read_i | input | 1 | Register read strobe, clears the capture flags |
| pwm_o | output | 1 | Waveform output |
| cnt_o | output | 32 | Counter value |
| cc_o | output | 32 | Active compare/capture register |
| cap_flag_o | output | 1 | Unread capture pending |
| cap_ovf_o | output | 1 | Capture lost over an unread one |

## Verification
On every cycle, the assertions check the following. The active register holds still between wraps outside capture mode. The counter stays within a stable top value. The output stays low in capture mode and holds between wraps in match-frequency mode. A nonzero compare drives the output high at the start of a frame. The capture flags follow read and capture as specified, and a zero dither width never produces an extended frame. Some properties span many frames, so only the bench scenarios can show them. These are the exact count of extended frames per group, the duty totals under each resolution, and the delay of an update to the frame boundary.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  typedef enum logic [1:0] {
    MODE_PWM  = 2'd0,
    MODE_MFRQ = 2'd1,
    MODE_CAPT = 2'd2,
    MODE_PWM2 = 2'd3
  } chan_mode_e;

  localparam int DITH_MAX = 6;

  // dither width selected by the resolution code
  function automatic logic [2:0] dith_bits(input logic [1:0] res);
    case (res)
      2'd1:    dith_bits = 3'd4;
      2'd2:    dith_bits = 3'd5;
      2'd3:    dith_bits = 3'd6;
      default: dith_bits = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q;

  assign wrap_o = (cnt_q >= top_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // counter never exceeds a top value that holds still
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    ($stable(top_i) && ($past(cnt_q) <= top_i)) |-> (cnt_q <= top_i));

endmodule

// File: rtl/dpwm_ccreg.sv
module dpwm_ccreg
  import dpwm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  chan_mode_e   mode_i,
  input  logic         wrap_i,
  input  logic [W-1:0] cnt_i,
  input  logic         buf_wr_i,
  input  logic [W-1:0] buf_data_i,
  input  logic         update_i,
  input  logic         capture_i,
  input  logic         read_i,
  output logic [W-1:0] cc_o,
  output logic         flag_o,
  output logic         ovf_o
);

  logic [W-1:0] shadow_q;
  logic [W-1:0] cc_q;
  logic         pend_q;
  logic         flag_q;
  logic         ovf_q;
  logic         capt_mode;
  logic         cap_ev;
  logic         load_now;

  assign capt_mode = (mode_i == MODE_CAPT);
  assign cap_ev    = capt_mode && capture_i;
  assign load_now  = !capt_mode && wrap_i && (pend_q || update_i);

  always_ff @(posedge clk) begin
    if (rst)           shadow_q <= '0;
    else if (buf_wr_i) shadow_q <= buf_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                      pend_q <= 1'b0;
    else if (capt_mode || load_now) pend_q <= 1'b0;
    else if (update_i)            pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           cc_q <= '0;
    else if (cap_ev)   cc_q <= cnt_i;
    else if (load_now) cc_q <= shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (cap_ev)      flag_q <= 1'b1;
      else if (read_i) flag_q <= 1'b0;
      if (read_i)                ovf_q <= 1'b0;
      else if (cap_ev && flag_q) ovf_q <= 1'b1;
    end
  end

  assign cc_o   = cc_q;
  assign flag_o = flag_q;
  assign ovf_o  = ovf_q;

  // active register only moves at a wrap outside capture mode
  assert_hold_between_wraps_R2: assert property (@(posedge clk) disable iff (rst)
    (!wrap_i && !capt_mode) |=> $stable(cc_q));

  assert_ovf_on_lost_capture_R9: assert property (@(posedge clk) disable iff (rst)
    (capt_mode && capture_i && flag_q && !read_i) |=> ovf_q);

  assert_read_clears_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (read_i && !capture_i) |=> (!flag_q && !ovf_q));

endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither
  import dpwm_pkg::*;
#(
  parameter bit DITHER_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrap_i,
  input  logic [1:0]          res_i,
  input  logic [DITH_MAX-1:0] dith_i,
  output logic                ext_o
);

  generate
    if (DITHER_EN) begin : g_acc
      logic [DITH_MAX-1:0] acc_q;
      logic [DITH_MAX-1:0] mask;
      logic [DITH_MAX:0]   sum;
      logic [2:0]          nbits;
      logic                ext_q;

      assign nbits = dith_bits(res_i);
      assign mask  = ~({DITH_MAX{1'b1}} << nbits);
      assign sum   = {1'b0, acc_q & mask} + {1'b0, dith_i & mask};

      always_ff @(posedge clk) begin
        if (rst) begin
          acc_q <= '0;
          ext_q <= 1'b0;
        end else if (wrap_i) begin
          acc_q <= sum[DITH_MAX-1:0] & mask;
          ext_q <= sum[nbits];
        end
      end

      assign ext_o = ext_q;

      // zero dither width never yields an extended frame
      assert_no_ext_without_dither_R5: assert property (@(posedge clk) disable iff (rst)
        (wrap_i && (res_i == 2'd0)) |=> !ext_q);
    end else begin : g_none
      logic unused_in;
      assign unused_in = clk ^ rst ^ wrap_i ^ (^res_i) ^ (^dith_i);
      assign ext_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/dpwm_wavegen.sv
module dpwm_wavegen
  import dpwm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  chan_mode_e   mode_i,
  input  logic         wrap_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         ext_i,
  output logic         pwm_o
);

  logic [W:0] eff;
  logic       pwm_q;

  assign eff = {1'b0, cmp_i} + {{W{1'b0}}, ext_i};

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else begin
      case (mode_i)
        MODE_CAPT: pwm_q <= 1'b0;
        MODE_MFRQ: if (wrap_i) pwm_q <= ~pwm_q;
        default:   pwm_q <= ({1'b0, cnt_i} < eff);
      endcase
    end
  end

  assign pwm_o = pwm_q;

  assert_low_in_capture_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_CAPT) |=> !pwm_q);

  assert_mfrq_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == MODE_MFRQ) && !wrap_i) |=> $stable(pwm_q));

  assert_frame_start_high_R4: assert property (@(posedge clk) disable iff (rst)
    (((mode_i == MODE_PWM) || (mode_i == MODE_PWM2)) && (cnt_i == '0) && (cmp_i != '0))
      |=> pwm_q);

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
  import dpwm_pkg::*;
#(
  parameter int W         = 32,
  parameter bit DITHER_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode_i,
  input  logic [1:0]   res_i,
  input  logic [W-1:0] period_i,
  input  logic         buf_wr_i,
  input  logic [W-1:0] buf_data_i,
  input  logic         update_i,
  input  logic         capture_i,
  input  logic         read_i,
  output logic         pwm_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cc_o,
  output logic         cap_flag_o,
  output logic         cap_ovf_o
);

  chan_mode_e   mode;
  logic [2:0]   nbits;
  logic [W-1:0] cc_q;
  logic [W-1:0] cmp_field;
  logic [W-1:0] top;
  logic [W-1:0] cnt;
  logic         wrap;
  logic         ext;

  assign mode      = chan_mode_e'(mode_i);
  assign nbits     = dith_bits(res_i);
  assign cmp_field = cc_q >> nbits;
  assign top       = (mode == MODE_MFRQ) ? cmp_field : period_i;

  dpwm_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .top_i  (top),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  dpwm_ccreg #(.W(W)) u_cc (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .wrap_i     (wrap),
    .cnt_i      (cnt),
    .buf_wr_i   (buf_wr_i),
    .buf_data_i (buf_data_i),
    .update_i   (update_i),
    .capture_i  (capture_i),
    .read_i     (read_i),
    .cc_o       (cc_q),
    .flag_o     (cap_flag_o),
    .ovf_o      (cap_ovf_o)
  );

  dpwm_dither #(.DITHER_EN(DITHER_EN)) u_dith (
    .clk    (clk),
    .rst    (rst),
    .wrap_i (wrap),
    .res_i  (res_i),
    .dith_i (cc_q[DITH_MAX-1:0]),
    .ext_o  (ext)
  );

  dpwm_wavegen #(.W(W)) u_wave (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode),
    .wrap_i (wrap),
    .cnt_i  (cnt),
    .cmp_i  (cmp_field),
    .ext_i  (ext),
    .pwm_o  (pwm_o)
  );

  assign cnt_o = cnt;
  assign cc_o  = cc_q;

endmodule

// File: tb/dpwm_channel_test.sv
module dpwm_channel_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode_i = 2'd0;
  logic [1:0]   res_i = 2'd0;
  logic [W-1:0] period_i = 32'd9;
  logic         buf_wr_i = 1'b0;
  logic [W-1:0] buf_data_i = '0;
  logic         update_i = 1'b0;
  logic         capture_i = 1'b0;
  logic         read_i = 1'b0;
  logic         pwm_o;
  logic [W-1:0] cnt_o;
  logic [W-1:0] cc_o;
  logic         cap_flag_o;
  logic         cap_ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dpwm_channel #(.W(W)) uut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .res_i(res_i), .period_i(period_i),
    .buf_wr_i(buf_wr_i), .buf_data_i(buf_data_i), .update_i(update_i),
    .capture_i(capture_i), .read_i(read_i), .pwm_o(pwm_o), .cnt_o(cnt_o),
    .cc_o(cc_o), .cap_flag_o(cap_flag_o), .cap_ovf_o(cap_ovf_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nb(input int res);
    case (res)
      1: return 4;
      2: return 5;
      3: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // high cycles over P*2^n cycles
  function automatic int exp_high(input int p, input int n, input int c, input int d);
    int f = 1 << n;
    return d * imin(c + 1, p) + (f - d) * imin(c, p);
  endfunction

  task automatic load_value(input logic [W-1:0] val);
    @(negedge clk); buf_wr_i = 1'b1; buf_data_i = val;
    @(negedge clk); buf_wr_i = 1'b0; update_i = 1'b1;
    @(negedge clk); update_i = 1'b0;
    for (int i = 0; i < 300 && cc_o != val; i++) @(negedge clk);
  endtask

  task automatic measure(input string req, input int p, input int n, input int c, input int d);
    int hi = 0;
    repeat (3 * p + 4) @(negedge clk);
    for (int i = 0; i < (p << n); i++) begin
      if (pwm_o) hi++;
      @(negedge clk);
    end
    check(req, hi, exp_high(p, n, c, d));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int mx;
    int tg;
    logic [W-1:0] v;
    logic prev;
    seed = $urandom(32'd4242);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 cc", cc_o, 0);
    check("R1 cnt", cnt_o, 1);
    check("R1 pwm", pwm_o, 0);
    check("R1 flag", cap_flag_o, 0);
    check("R1 ovf", cap_ovf_o, 0);

    // R6 counter range with period 9
    mx = 0;
    for (int i = 0; i < 40; i++) begin
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
      @(negedge clk);
    end
    check("R6 max count", mx, 9);

    // R4 plain PWM, no dither: C=4 P=10
    load_value(32'd4);
    check("R2 loaded", cc_o, 4);
    measure("R4 duty C4", 10, 0, 4, 0);
    // R4 compare above period: always high
    load_value(32'd15);
    measure("R4 saturate", 10, 0, 15, 0);
    // R4 zero compare: never high
    load_value(32'd0);
    measure("R4 zero", 10, 0, 0, 0);

    // R3 R5 directed dither cases
    res_i = 2'd3;
    load_value((32'd4 << 6) | 32'd13);
    measure("R5 n6 C4 D13", 10, 6, 4, 13);
    res_i = 2'd1;
    load_value((32'd3 << 4) | 32'd5);
    measure("R3 n4 C3 D5", 10, 4, 3, 5);
    res_i = 2'd2;
    load_value((32'd9 << 5) | 32'd31);
    measure("R5 n5 C9 D31 edge", 10, 5, 9, 31);

    // R2 buffer write without update leaves register alone
    res_i = 2'd0;
    load_value(32'd6);
    @(negedge clk); buf_wr_i = 1'b1; buf_data_i = 32'd3;
    @(negedge clk); buf_wr_i = 1'b0;
    repeat (30) @(negedge clk);
    check("R2 no update", cc_o, 6);
    for (int i = 0; i < 20 && cnt_o != 2; i++) @(negedge clk);
    update_i = 1'b1;
    @(negedge clk); update_i = 1'b0;
    check("R2 before wrap", cc_o, 6);
    for (int i = 0; i < 20 && cnt_o != 0; i++) @(negedge clk);
    check("R2 after wrap", cc_o, 3);

    // random mix R4 R5 R3 R6
    for (int k = 0; k < 8; k++) begin
      int r, n, p, c, d;
      r = int'($urandom % 4);
      n = nb(r);
      p = 4 + int'($urandom % 12);
      c = int'($urandom % (p + 2));
      d = (n == 0) ? 0 : int'($urandom % (1 << n));
      res_i = r[1:0];
      period_i = p - 1;
      load_value((c << n) | d);
      measure("R5 random", p, n, c, d);
    end

    // R7 match-frequency: compare 7 -> period 8
    res_i = 2'd0;
    period_i = 32'd9;
    load_value(32'd7);
    mode_i = 2'd1;
    repeat (20) @(negedge clk);
    mx = 0; tg = 0; prev = pwm_o;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
      if (pwm_o != prev) tg++;
      prev = pwm_o;
    end
    check("R7 top", mx, 7);
    check("R7 toggles", tg, 10);

    // R8 capture mode
    mode_i = 2'd2;
    repeat (12) @(negedge clk);
    check("R8 pwm low", pwm_o, 0);
    v = cnt_o; capture_i = 1'b1;
    @(negedge clk); capture_i = 1'b0;
    check("R8 captured", cc_o, v);
    check("R8 flag", cap_flag_o, 1);
    check("R9 no ovf", cap_ovf_o, 0);
    @(negedge clk); @(negedge clk);
    v = cnt_o; capture_i = 1'b1;
    @(negedge clk); capture_i = 1'b0;
    check("R9 ovf", cap_ovf_o, 1);
    check("R8 second capture", cc_o, v);
    read_i = 1'b1;
    @(negedge clk); read_i = 1'b0;
    check("R9 read flag", cap_flag_o, 0);
    check("R9 read ovf", cap_ovf_o, 0);
    capture_i = 1'b1; read_i = 1'b1;
    @(negedge clk); capture_i = 1'b0; read_i = 1'b0;
    check("R9 same cycle flag", cap_flag_o, 1);
    check("R9 same cycle ovf", cap_ovf_o, 0);
    // update ignored in capture mode
    v = cc_o;
    @(negedge clk); buf_wr_i = 1'b1; buf_data_i = 32'd2;
    @(negedge clk); buf_wr_i = 1'b0; update_i = 1'b1;
    @(negedge clk); update_i = 1'b0;
    repeat (30) @(negedge clk);
    check("R8 update ignored", cc_o, v);
    check("R8 pwm still low", pwm_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule